// File: doc/BRIEF.md
# NAND Flash Controller Register Front-End

This block is the software-facing register file and run sequencer of a NAND flash controller. A host reaches it through a plain 32-bit register port: a write strobe with address and data, and a read path whose data follows the address in the same cycle. It holds a control word, two timing words, a page-count word and a write-one-to-clear status word. It drives one interrupt line, formed from the status bits that the control word's mask field leaves enabled.

A command starts when software raises the run bit. The block answers by posting a command-request status bit. Once software has cleared that bit, it pushes three words in a row into a single command-buffer address. The block latches them as command words 0, 1 and 2 and gives the core a one-cycle valid strobe. A built-in completion stub stands in for the pin sequencer. A fixed number of cycles after the strobe, it reports the command finished: it posts the done and ready bits for the chip select picked by word 0 bit 24, and it drops the run bit. Core-side data-request and ECC error events enter through a small event input. They land directly in status.

Top module: `nfc_regfront`

## Requirements
- R1: After reset every register reads 0, the run output is 0, the interrupt is 0 and the command-valid strobe is 0.
- R2: The timing words (offsets 0x04, 0x0C) and page count (0x18) read back exactly what was written. The control word (0x00) reads back what was written except bit 28, which the finish logic may clear.
- R3: Writing control with bit 28 set while run is low sets status bit 0 (command request), visible the cycle after the write. The run output follows bit 28.
- R4: While run is high and status bit 0 is clear, the first three writes to offset 0x48 are latched in order as command words 0, 1 and 2. The strobe cmd_valid is high for exactly the one cycle after the third write.
- R5: A write to 0x48 made while run is low, while status bit 0 is still set, or after three words were taken leaves the command words unchanged and raises no strobe. It sets sticky error status bit 13.
- R6: CMD_LATENCY+1 cycles after the cycle in which cmd_valid is high, run drops to 0. If word 0 bit 24 is 0, status bits 8 (done) and 11 (ready) are set. If it is 1, bits 7 and 12 are set instead.
- R7: Status bits 13:0 clear when written with 1 and keep their value when written with 0. A write of 0xFFF therefore clears bits 11:0 and leaves bits 12 and 13.
- R8: core_evt bits 0..3 set status bits 1..4 (read request, write request, single-bit error, double-bit error). When a set and a write-one-to-clear hit the same bit in one cycle, the set wins.
- R9: irq is high exactly when some status bit n in 11:0 is set with control mask bit n equal to 0, or status bit 12 is set (bit 12 has no mask). Error bit 13 never drives irq.
- R10: Clearing control bit 28 by software before completion stops the command. No done or ready bits are posted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| irq | output | 1 | Interrupt, unmasked status OR |
| core_evt | input | 4 | Core events: read request, write request, single-bit error, double-bit error |
| core_run | output | 1 | Run state to the core |
| cmd_word0 | output | 32 | Latched command word 0 |
| cmd_word1 | output | 32 | Latched command word 1 |
| cmd_word2 | output | 32 | Latched command word 2 |
| cmd_valid | output | 1 | One-cycle strobe after the third command word |

## Verification
The two functions that can meet in one cycle are a software write-one-to-clear of status and a hardware set of the same status bit. The bench provokes this by driving a core read-request event on the same clock edge as a status write that clears bit 1. It judges the outcome by reading bit 1 back as still set. A second overlap, a software stop landing on the same edge where the completion stub arms, is judged by the absence of any done or ready bit long after the latency has run out.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  localparam int OFF_CTRL   = 'h00;
  localparam int OFF_TIM0   = 'h04;
  localparam int OFF_TIM1   = 'h0C;
  localparam int OFF_STAT   = 'h14;
  localparam int OFF_PGCNT  = 'h18;
  localparam int OFF_CMDBUF = 'h48;

  localparam int ST_W       = 14;
  localparam int RUN_BIT    = 28;
  localparam int MASK_W     = 12;
  localparam int ST_CMDREQ  = 0;
  localparam int ST_EVT_LO  = 1;
  localparam int ST_DONE1   = 7;
  localparam int ST_DONE0   = 8;
  localparam int ST_RDY0    = 11;
  localparam int ST_RDY1    = 12;
  localparam int ST_ERR     = 13;
  localparam int CSEL_BIT   = 24;

  typedef logic [ST_W-1:0] status_t;

  function automatic status_t f_status_next(status_t cur, status_t clr, status_t set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic f_irq(status_t st, logic [MASK_W-1:0] mask);
    return (|(st[MASK_W-1:0] & ~mask)) | st[ST_RDY1];
  endfunction
endpackage

// File: rtl/nfc_status.sv
module nfc_status
  import nfc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clr_en,
  input  status_t clr_bits,
  input  status_t set_bits,
  output status_t status
);
  status_t clr_eff;
  assign clr_eff = clr_en ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= f_status_next(status, clr_eff, set_bits);
  end
endmodule

// File: rtl/nfc_cmd_latch.sv
module nfc_cmd_latch #(
  parameter int DW    = 32,
  parameter int WORDS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cmd,
  input  logic [DW-1:0] wdata,
  input  logic          run,
  input  logic          run_rise,
  input  logic          req_pending,
  output logic [DW-1:0] words [WORDS],
  output logic          valid,
  output logic          accept,
  output logic          reject
);
  localparam int CW = $clog2(WORDS + 1);
  logic [CW-1:0] cnt;

  assign accept = wr_cmd && run && !req_pending && (cnt < CW'(WORDS));
  assign reject = wr_cmd && !accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      valid <= 1'b0;
    end else begin
      valid <= accept && (cnt == CW'(WORDS - 1));
      if (run_rise || !run) cnt <= '0;
      else if (accept)      cnt <= cnt + 1'b1;
    end
  end

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) words[i] <= '0;
      else if (accept && cnt == CW'(i)) words[i] <= wdata;
    end
  end
endmodule

// File: rtl/nfc_done_stub.sv
module nfc_done_stub #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(LAT + 1);
  logic [CW-1:0] cnt;
  logic          busy;

  assign done = busy && run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!run) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(LAT - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/nfc_regfront.sv
module nfc_regfront
  import nfc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DW          = 32,
  parameter int EVT_W       = 4,
  parameter int CMD_LATENCY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq,
  input  logic [EVT_W-1:0]  core_evt,
  output logic              core_run,
  output logic [DW-1:0]     cmd_word0,
  output logic [DW-1:0]     cmd_word1,
  output logic [DW-1:0]     cmd_word2,
  output logic              cmd_valid
);
  localparam int NWORDS = 3;

  logic [DW-1:0] ctrl_q, tim0_q, tim1_q, pgcnt_q;
  logic [DW-1:0] words [NWORDS];
  status_t       status, set_bits;
  logic          wr_ctrl, wr_tim0, wr_tim1, wr_stat, wr_pgcnt, wr_cmd;
  logic          run_rise, cmd_accept, cmd_reject, done_evt, cs_sel;

  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_tim0  = bus_wr && (bus_addr == ADDR_W'(OFF_TIM0));
  assign wr_tim1  = bus_wr && (bus_addr == ADDR_W'(OFF_TIM1));
  assign wr_stat  = bus_wr && (bus_addr == ADDR_W'(OFF_STAT));
  assign wr_pgcnt = bus_wr && (bus_addr == ADDR_W'(OFF_PGCNT));
  assign wr_cmd   = bus_wr && (bus_addr == ADDR_W'(OFF_CMDBUF));

  assign core_run = ctrl_q[RUN_BIT];
  assign run_rise = wr_ctrl && bus_wdata[RUN_BIT] && !core_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      tim0_q  <= '0;
      tim1_q  <= '0;
      pgcnt_q <= '0;
    end else begin
      if (wr_ctrl)  ctrl_q <= bus_wdata;
      if (done_evt) ctrl_q[RUN_BIT] <= 1'b0;
      if (wr_tim0)  tim0_q  <= bus_wdata;
      if (wr_tim1)  tim1_q  <= bus_wdata;
      if (wr_pgcnt) pgcnt_q <= bus_wdata;
    end
  end

  nfc_cmd_latch #(.DW(DW), .WORDS(NWORDS)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wdata(bus_wdata),
    .run(core_run), .run_rise(run_rise), .req_pending(status[ST_CMDREQ]),
    .words(words), .valid(cmd_valid), .accept(cmd_accept), .reject(cmd_reject)
  );

  assign cmd_word0 = words[0];
  assign cmd_word1 = words[1];
  assign cmd_word2 = words[2];
  assign cs_sel    = words[0][CSEL_BIT];

  nfc_done_stub #(.LAT(CMD_LATENCY)) u_stub (
    .clk(clk), .rst_n(rst_n), .start(cmd_valid), .run(core_run), .done(done_evt)
  );

  always_comb begin
    set_bits = '0;
    set_bits[ST_CMDREQ] = run_rise;
    set_bits[ST_EVT_LO +: EVT_W] = core_evt;
    set_bits[ST_DONE0] = done_evt && !cs_sel;
    set_bits[ST_RDY0]  = done_evt && !cs_sel;
    set_bits[ST_DONE1] = done_evt && cs_sel;
    set_bits[ST_RDY1]  = done_evt && cs_sel;
    set_bits[ST_ERR]   = cmd_reject;
  end

  nfc_status u_status (
    .clk(clk), .rst_n(rst_n), .clr_en(wr_stat), .clr_bits(bus_wdata[ST_W-1:0]),
    .set_bits(set_bits), .status(status)
  );

  assign irq = f_irq(status, ctrl_q[MASK_W-1:0]);

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFF_CTRL):  bus_rdata = ctrl_q;
      ADDR_W'(OFF_TIM0):  bus_rdata = tim0_q;
      ADDR_W'(OFF_TIM1):  bus_rdata = tim1_q;
      ADDR_W'(OFF_STAT):  bus_rdata = DW'(status);
      ADDR_W'(OFF_PGCNT): bus_rdata = pgcnt_q;
      default:            bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/nfc_regfront_chk.sv
module nfc_regfront_chk
  import nfc_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_rise,
  input logic          cmd_accept,
  input logic          cmd_reject,
  input logic          cmd_valid,
  input logic          done_evt,
  input logic          core_run,
  input logic [DW-1:0] cmd_word0,
  input logic [3:0]    core_evt,
  input status_t       status
);
  a_r3_req_on_run: assert property (@(posedge clk) disable iff (!rst_n)
    run_rise |=> (status[ST_CMDREQ] && core_run));

  a_r4_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  a_r4_valid_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> $past(cmd_accept));

  a_r5_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_accept |=> $stable(cmd_word0));

  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |=> status[ST_ERR]);

  a_r6_run_drops: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !core_run);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    core_evt[0] |=> status[ST_EVT_LO]);
endmodule

bind nfc_regfront nfc_regfront_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .run_rise(run_rise), .cmd_accept(cmd_accept),
  .cmd_reject(cmd_reject), .cmd_valid(cmd_valid), .done_evt(done_evt),
  .core_run(core_run), .cmd_word0(cmd_word0), .core_evt(core_evt), .status(status)
);

// File: tb/nfc_regfront_tb.sv
module nfc_regfront_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 4;

  logic        clk = 0, rst_n = 0;
  logic        bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        irq, core_run, cmd_valid;
  logic [3:0]  core_evt = 0;
  logic [31:0] cmd_word0, cmd_word1, cmd_word2;

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nfc_regfront #(.CMD_LATENCY(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .core_evt(core_evt),
    .core_run(core_run), .cmd_word0(cmd_word0), .cmd_word1(cmd_word1),
    .cmd_word2(cmd_word2), .cmd_valid(cmd_valid)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_cmd(logic [31:0] w0, logic [31:0] w1, logic [31:0] w2);
    exp_q.push_back(w0); exp_q.push_back(w1); exp_q.push_back(w2);
    wr(8'h48, w0); wr(8'h48, w1); wr(8'h48, w2);
  endtask

  // monitor: pops one expected command per valid strobe (R4)
  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      if (exp_q.size() < 3) begin
        n_chk++; n_bad++;
        $display("FAIL R4: unexpected cmd_valid actual 1 expected 0");
      end else begin
        chk("R4 word0", cmd_word0, exp_q.pop_front());
        chk("R4 word1", cmd_word1, exp_q.pop_front());
        chk("R4 word2", cmd_word2, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    idle(2); rst_n = 1; idle(1);
    // R1 reset state
    rd(8'h00, d); chk("R1 ctrl", d, 0);
    rd(8'h14, d); chk("R1 status", d, 0);
    chk("R1 irq/run/valid", {irq, core_run, cmd_valid}, 0);

    // R2 readback
    wr(8'h04, 32'hA5A5_1234); rd(8'h04, d); chk("R2 tim0", d, 32'hA5A5_1234);
    wr(8'h0C, 32'h0F0F_5678); rd(8'h0C, d); chk("R2 tim1", d, 32'h0F0F_5678);
    wr(8'h18, 32'h0000_0042); rd(8'h18, d); chk("R2 pgcnt", d, 32'h42);

    // R5 write while run low
    wr(8'h48, 32'hDEAD_0001);
    rd(8'h14, d); chk("R5 run low err", d, 32'h2000);
    chk("R5 run low word0", cmd_word0, 0);
    wr(8'h14, 32'h2000);

    // R3 run rise
    wr(8'h00, 32'h1000_0FFF);
    rd(8'h14, d); chk("R3 cmd req", d, 32'h1);
    chk("R3 run", {31'b0, core_run}, 1);
    chk("R9 all masked", {31'b0, irq}, 0);

    // R5 write while request pending
    wr(8'h48, 32'hDEAD_0002);
    rd(8'h14, d); chk("R5 pending err", d, 32'h2001);
    wr(8'h14, 32'h2001);

    // R4 three words, then R5 fourth word, R6 exact completion cycle
    send_cmd(32'h0000_3000, 32'h1234_5678, 32'h0000_00AB);
    wr(8'h48, 32'hBAD0_0004);
    chk("R5 extra word0", cmd_word0, 32'h0000_3000);
    idle(LAT - 1);
    chk("R6 run still high", {31'b0, core_run}, 1);
    idle(1);
    chk("R6 run dropped", {31'b0, core_run}, 0);
    rd(8'h14, d); chk("R6 cs0 done/ready", d, 32'h2900);
    rd(8'h00, d); chk("R2 ctrl readback", d, 32'h0000_0FFF);

    // R9 masking
    wr(8'h00, 32'h0000_0EFF); chk("R9 unmasked done", {31'b0, irq}, 1);
    wr(8'h00, 32'h0000_0FFF); chk("R9 remasked", {31'b0, irq}, 0);

    // R7 clear
    wr(8'h14, 32'h0FFF); rd(8'h14, d); chk("R7 0xFFF keeps 13", d, 32'h2000);
    wr(8'h14, 32'h2000); rd(8'h14, d); chk("R7 clear 13", d, 0);

    // R6 chip select 1
    wr(8'h00, 32'h1000_0FFF); wr(8'h14, 32'h1);
    send_cmd(32'h0100_0090, 32'h0, 32'h0);
    idle(LAT + 1);
    rd(8'h14, d); chk("R6 cs1 done/ready", d, 32'h1080);
    chk("R9 bit12 unmaskable", {31'b0, irq}, 1);
    wr(8'h14, 32'h0FFF); rd(8'h14, d); chk("R7 0xFFF keeps 12", d, 32'h1000);
    wr(8'h14, 32'h1000);

    // R8 set wins over clear, and event mapping
    core_evt = 4'b0001; bus_wr = 1; bus_addr = 8'h14; bus_wdata = 32'h2;
    @(posedge clk); @(negedge clk); bus_wr = 0; core_evt = 0;
    rd(8'h14, d); chk("R8 set wins", d, 32'h2);
    core_evt = 4'b1111; @(posedge clk); @(negedge clk); core_evt = 0;
    rd(8'h14, d); chk("R8 event map", d, 32'h1E);
    wr(8'h14, 32'h1E);

    // R10 software stop
    wr(8'h00, 32'h1000_0FFF); wr(8'h14, 32'h1);
    send_cmd(32'h0000_1080, 32'h5, 32'h6);
    wr(8'h00, 32'h0000_0FFF);
    idle(LAT + 4);
    rd(8'h14, d); chk("R10 no done after stop", d, 0);
    chk("R10 run low", {31'b0, core_run}, 0);
    chk("R4 queue drained", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule